// File: doc/BRIEF.md
# Indirect SDRAM Controller Register File

This block holds the control and status registers of an SDRAM controller and exposes them through only two bus locations. One location is a pointer: software writes the internal offset of the register it wants, and can read that pointer back. The other location is a window: a read or write there acts on whichever internal register the pointer currently selects. The window read data is combinational from registered state, so a read completes in the cycle it is issued.

Each internal register has its own write behaviour. The error status words only ever lose bits: a 1 written to a bit position clears that bit. Several registers keep only some of the written bits. The status word cannot be written and instead follows edges of two control bits. The power-management word always has one group of bits forced to 1. The ECC error word drives an interrupt line that is high exactly while that word is nonzero. The control word's top bit is the global memory enable, which gates the per-bank enable bits held in the bank words. The bank words and the per-bank active flags are block outputs. Banks built as absent ignore writes.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A write to bus location `LOC_INDEX` (default 0x10) loads all 32 bits of the pointer, and a read there returns it. Reads of any bus location other than `LOC_INDEX` and `LOC_WINDOW` (default 0x11) return 0, writes there change nothing, and `bus_rdata` is 0 while `bus_sel` is low.
- R2: A read of `LOC_WINDOW` returns, in the same cycle, the register at the pointer's offset: 0x00 error status A, 0x08 error status B, 0x10 error address, 0x20 control, 0x24 status, 0x30 refresh, 0x34 power management, 0x40+4*i bank word i, 0x94 ECC control, 0x98 ECC error. Offset 0x80 (timing) and every other pointer value read 0xFFFFFFFF; window writes to them have no effect.
- R3: After reset, control reads 0x00800000, power management 0x07C00000, refresh 0x05F00000, and the pointer, error words, status, ECC words and bank words read 0.
- R4: A window write to either error status word clears each bit written as 1 and sets none; a write to the error address stores the full 32-bit value.
- R5: A window write to control stores the written value ANDed with 0xFFE00000.
- R6: When control bit 31 goes from 0 to 1, status bit 31 becomes 0; when it goes from 1 to 0, status bit 31 becomes 1. `mem_enable` equals control bit 31.
- R7: When control bit 30 goes from 0 to 1, status bit 30 becomes 1; when it goes from 1 to 0, it becomes 0. Window writes to status change nothing.
- R8: Refresh stores the written value ANDed with 0x3FF80000, ECC control ANDed with 0x00F00000, and power management stores (value AND 0xF8000000) OR 0x07C00000.
- R9: ECC error stores the written value ANDed with 0xFFF0F000, and `ecc_irq` is 1 exactly while the stored ECC error word is nonzero, updating on the same edge.
- R10: Bank word i stores the written value ANDed with 0xFFDEE001 and appears on `bank_words[32*i+31:32*i]`; a bank whose bit in `BANK_FITTED` is 0 ignores writes and reads 0.
- R11: `bank_active[i]` is 1 exactly when `mem_enable` is 1 and bit 0 of bank word i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_loc | input | LOC_W | Bus location of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| mem_enable | output | 1 | Global memory enable (control bit 31) |
| ecc_irq | output | 1 | ECC error interrupt, level |
| bank_words | output | 32*NBANK | Bank words, bank 0 in the low bits |
| bank_active | output | NBANK | Per-bank enable gated by the global enable |

## Verification
The bench builds the block with four banks and `BANK_FITTED` set to 4'b1011, so that both a populated bank and an absent bank sit side by side in the bank window and the ignored writes to the absent one can be seen at its read port. With only 256 low pointer values of interest, every offset is read back after reset and after each full sweep of writes with several data patterns, so every mask, the undefined-offset response, and the edge-driven status bits are compared against an arithmetic model of the requirements. Directed sequences then walk the enable and interrupt edges and the pointer's behaviour at other bus locations.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    localparam int DW = 32;

    // internal offsets (the bank window base sets bank i at base + 4*i)
    localparam logic [DW-1:0] OFS_ERRST_A = 32'h0000_0000;
    localparam logic [DW-1:0] OFS_ERRST_B = 32'h0000_0008;
    localparam logic [DW-1:0] OFS_ERRADR  = 32'h0000_0010;
    localparam logic [DW-1:0] OFS_CTRL    = 32'h0000_0020;
    localparam logic [DW-1:0] OFS_STAT    = 32'h0000_0024;
    localparam logic [DW-1:0] OFS_REFR    = 32'h0000_0030;
    localparam logic [DW-1:0] OFS_PWR     = 32'h0000_0034;
    localparam logic [DW-1:0] OFS_BANK    = 32'h0000_0040;
    localparam logic [DW-1:0] OFS_TIMING  = 32'h0000_0080;
    localparam logic [DW-1:0] OFS_ECCCTL  = 32'h0000_0094;
    localparam logic [DW-1:0] OFS_ECCERR  = 32'h0000_0098;

    // write masks
    localparam logic [DW-1:0] MSK_CTRL    = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_REFR    = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR     = 32'hF800_0000;
    localparam logic [DW-1:0] PWR_FORCED  = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_ECCCTL  = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_ECCERR  = 32'hFFF0_F000;
    localparam logic [DW-1:0] MSK_BANK    = 32'hFFDE_E001;

    // reset values
    localparam logic [DW-1:0] RST_CTRL    = 32'h0080_0000;
    localparam logic [DW-1:0] RST_REFR    = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR     = 32'h07C0_0000;

    localparam int BIT_EN   = 31;
    localparam int BIT_AUX  = 30;

    typedef struct packed {
        logic errst_a;
        logic errst_b;
        logic erradr;
        logic ctrl;
        logic stat;
        logic refr;
        logic pwr;
        logic timing;
        logic eccctl;
        logic eccerr;
    } hit_t;

    typedef struct packed {
        logic [DW-1:0] ptr;
        logic [DW-1:0] errst_a;
        logic [DW-1:0] errst_b;
        logic [DW-1:0] erradr;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] stat;
        logic [DW-1:0] refr;
        logic [DW-1:0] pwr;
        logic [DW-1:0] eccctl;
        logic [DW-1:0] eccerr;
        logic          irq;
    } core_t;

endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic [DW-1:0]    ptr,
    output hit_t             hit,
    output logic [NBANK-1:0] bank_hit
);

    always_comb begin
        hit         = '0;
        hit.errst_a = (ptr == OFS_ERRST_A);
        hit.errst_b = (ptr == OFS_ERRST_B);
        hit.erradr  = (ptr == OFS_ERRADR);
        hit.ctrl    = (ptr == OFS_CTRL);
        hit.stat    = (ptr == OFS_STAT);
        hit.refr    = (ptr == OFS_REFR);
        hit.pwr     = (ptr == OFS_PWR);
        hit.timing  = (ptr == OFS_TIMING);
        hit.eccctl  = (ptr == OFS_ECCCTL);
        hit.eccerr  = (ptr == OFS_ECCERR);
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank_hit
        localparam logic [DW-1:0] BANK_OFS = OFS_BANK + DW'(4 * g);
        assign bank_hit[g] = (ptr == BANK_OFS);
    end

endmodule

// File: rtl/sdram_cfg_bank.sv
module sdram_cfg_bank
    import sdram_cfg_pkg::*;
#(
    parameter bit FITTED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          global_en,
    output logic [DW-1:0] word,
    output logic          active
);

    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en && FITTED) begin
            word_d = wdata & MSK_BANK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word   = word_q;
    assign active = global_en & word_q[0];

    // R10: no bit outside the bank mask is ever held
    p_bank_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q & ~MSK_BANK) == '0);

    if (!FITTED) begin : g_absent_chk
        // R10: an absent bank keeps its reset value whatever is written
        p_absent_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> word_q == '0);
    end

endmodule

// File: rtl/sdram_cfg_rdmux.sv
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  hit_t                hit,
    input  logic [NBANK-1:0]    bank_hit,
    input  core_t               regs,
    input  logic [NBANK*DW-1:0] bank_flat,
    output logic [DW-1:0]       data
);

    always_comb begin
        data = '1;
        if (hit.errst_a) data = regs.errst_a;
        if (hit.errst_b) data = regs.errst_b;
        if (hit.erradr)  data = regs.erradr;
        if (hit.ctrl)    data = regs.ctrl;
        if (hit.stat)    data = regs.stat;
        if (hit.refr)    data = regs.refr;
        if (hit.pwr)     data = regs.pwr;
        if (hit.eccctl)  data = regs.eccctl;
        if (hit.eccerr)  data = regs.eccerr;
        for (int i = 0; i < NBANK; i++) begin
            if (bank_hit[i]) data = bank_flat[i*DW +: DW];
        end
    end

endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int               NBANK       = 4,
    parameter logic [NBANK-1:0] BANK_FITTED = '1,
    parameter int               LOC_W       = 10,
    parameter logic [LOC_W-1:0] LOC_INDEX   = LOC_W'(16),
    parameter logic [LOC_W-1:0] LOC_WINDOW  = LOC_W'(17)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [LOC_W-1:0]    bus_loc,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                mem_enable,
    output logic                ecc_irq,
    output logic [NBANK*DW-1:0] bank_words,
    output logic [NBANK-1:0]    bank_active
);

    core_t            core_d, core_q;
    hit_t             hit;
    logic [NBANK-1:0] bank_hit;
    logic [DW-1:0]    win_data;
    logic             acc_ptr, acc_win, win_wr;
    logic [DW-1:0]    ctrl_new;

    assign acc_ptr = bus_sel && (bus_loc == LOC_INDEX);
    assign acc_win = bus_sel && (bus_loc == LOC_WINDOW);
    assign win_wr  = acc_win && bus_we;

    sdram_cfg_decode #(.NBANK(NBANK)) u_decode (
        .ptr      (core_q.ptr),
        .hit      (hit),
        .bank_hit (bank_hit)
    );

    assign ctrl_new = bus_wdata & MSK_CTRL;

    always_comb begin
        core_d = core_q;
        if (acc_ptr && bus_we) begin
            core_d.ptr = bus_wdata;
        end
        if (win_wr) begin
            if (hit.errst_a) core_d.errst_a = core_q.errst_a & ~bus_wdata;
            if (hit.errst_b) core_d.errst_b = core_q.errst_b & ~bus_wdata;
            if (hit.erradr)  core_d.erradr  = bus_wdata;
            if (hit.refr)    core_d.refr    = bus_wdata & MSK_REFR;
            if (hit.pwr)     core_d.pwr     = (bus_wdata & MSK_PWR) | PWR_FORCED;
            if (hit.eccctl)  core_d.eccctl  = bus_wdata & MSK_ECCCTL;
            if (hit.eccerr)  core_d.eccerr  = bus_wdata & MSK_ECCERR;
            if (hit.ctrl) begin
                if (!core_q.ctrl[BIT_EN] && ctrl_new[BIT_EN]) begin
                    core_d.stat[BIT_EN] = 1'b0;
                end else if (core_q.ctrl[BIT_EN] && !ctrl_new[BIT_EN]) begin
                    core_d.stat[BIT_EN] = 1'b1;
                end
                if (!core_q.ctrl[BIT_AUX] && ctrl_new[BIT_AUX]) begin
                    core_d.stat[BIT_AUX] = 1'b1;
                end else if (core_q.ctrl[BIT_AUX] && !ctrl_new[BIT_AUX]) begin
                    core_d.stat[BIT_AUX] = 1'b0;
                end
                core_d.ctrl = ctrl_new;
            end
        end
        core_d.irq = (core_d.eccerr != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.ctrl <= RST_CTRL;
            core_q.refr <= RST_REFR;
            core_q.pwr  <= RST_PWR;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_enable = core_q.ctrl[BIT_EN];
    assign ecc_irq    = core_q.irq;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_cfg_bank #(.FITTED(BANK_FITTED[g])) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (win_wr && bank_hit[g]),
            .wdata     (bus_wdata),
            .global_en (mem_enable),
            .word      (bank_words[g*DW +: DW]),
            .active    (bank_active[g])
        );
    end

    sdram_cfg_rdmux #(.NBANK(NBANK)) u_rdmux (
        .hit       (hit),
        .bank_hit  (bank_hit),
        .regs      (core_q),
        .bank_flat (bank_words),
        .data      (win_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc_ptr)      bus_rdata = core_q.ptr;
        else if (acc_win) bus_rdata = win_data;
    end

    // R9: interrupt level tracks a nonzero ECC error word
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_irq == (core_q.eccerr != '0));

    // R5: control never holds bits below the mask
    p_ctrl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.ctrl[20:0] == '0);

    // R8: forced power-management bits stay set
    p_pwr_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.pwr & PWR_FORCED) == PWR_FORCED);

    // R6: enabling clears status bit 31, disabling sets it
    p_en_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> !core_q.stat[BIT_EN]);
    p_en_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_enable) |-> core_q.stat[BIT_EN]);

    // R7: a write aimed at status leaves it untouched
    p_stat_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && hit.stat) |=> $stable(core_q.stat));

    // R4: error status words never gain bits
    p_errst_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.errst_a & ~$past(core_q.errst_a)) == '0) &&
        ((core_q.errst_b & ~$past(core_q.errst_b)) == '0));

    // R1: the pointer only moves on a pointer write
    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ptr && bus_we) |=> $stable(core_q.ptr));

endmodule

// File: tb/sdram_cfg_regfile_tb.sv
module sdram_cfg_regfile_tb;

    localparam int         NB    = 4;
    localparam logic [3:0] FIT   = 4'b1011;
    localparam int         LW    = 10;
    localparam logic [9:0] L_IDX = 10'h010;
    localparam logic [9:0] L_WIN = 10'h011;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0;
    logic           bus_we = 1'b0;
    logic [LW-1:0]  bus_loc = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           mem_enable;
    logic           ecc_irq;
    logic [NB*32-1:0] bank_words;
    logic [NB-1:0]  bank_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sdram_cfg_regfile #(
        .NBANK(NB), .BANK_FITTED(FIT), .LOC_W(LW),
        .LOC_INDEX(L_IDX), .LOC_WINDOW(L_WIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_loc(bus_loc), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_enable(mem_enable), .ecc_irq(ecc_irq),
        .bank_words(bank_words), .bank_active(bank_active)
    );

    // model of the requirements
    logic [31:0] m_ptr, m_ea, m_eb, m_adr, m_ctl, m_st, m_rf, m_pw, m_ec, m_ee;
    logic [31:0] m_bank [NB];

    task automatic model_reset();
        m_ptr = 0; m_ea = 0; m_eb = 0; m_adr = 0; m_st = 0; m_ec = 0; m_ee = 0;
        m_ctl = 32'h0080_0000; m_rf = 32'h05F0_0000; m_pw = 32'h07C0_0000;
        for (int i = 0; i < NB; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] p);
        logic [31:0] r;
        r = 32'hFFFF_FFFF;
        case (p)
            32'h00: r = m_ea;
            32'h08: r = m_eb;
            32'h10: r = m_adr;
            32'h20: r = m_ctl;
            32'h24: r = m_st;
            32'h30: r = m_rf;
            32'h34: r = m_pw;
            32'h94: r = m_ec;
            32'h98: r = m_ee;
            default: ;
        endcase
        for (int i = 0; i < NB; i++)
            if (p == 32'h40 + 32'(4 * i)) r = m_bank[i];
        return r;
    endfunction

    task automatic model_write(input logic [31:0] p, input logic [31:0] v);
        logic [31:0] nc;
        case (p)
            32'h00: m_ea = m_ea & ~v;
            32'h08: m_eb = m_eb & ~v;
            32'h10: m_adr = v;
            32'h20: begin
                nc = v & 32'hFFE0_0000;
                if (!m_ctl[31] && nc[31]) m_st[31] = 1'b0;
                if (m_ctl[31] && !nc[31]) m_st[31] = 1'b1;
                if (!m_ctl[30] && nc[30]) m_st[30] = 1'b1;
                if (m_ctl[30] && !nc[30]) m_st[30] = 1'b0;
                m_ctl = nc;
            end
            32'h30: m_rf = v & 32'h3FF8_0000;
            32'h34: m_pw = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h94: m_ec = v & 32'h00F0_0000;
            32'h98: m_ee = v & 32'hFFF0_F000;
            default: ;
        endcase
        for (int i = 0; i < NB; i++)
            if (p == 32'h40 + 32'(4 * i) && FIT[i]) m_bank[i] = v & 32'hFFDE_E001;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [LW-1:0] loc, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_loc = loc; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [LW-1:0] loc, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_loc = loc;
        #2 v = bus_rdata;
        #1 bus_sel = 1'b0;
    endtask

    task automatic win_write(input logic [31:0] p, input logic [31:0] v);
        bus_write(L_IDX, p);
        m_ptr = p;
        bus_write(L_WIN, v);
        model_write(p, v);
    endtask

    task automatic win_check(input string tag, input logic [31:0] p);
        logic [31:0] v;
        bus_write(L_IDX, p);
        m_ptr = p;
        bus_read(L_WIN, v);
        chk(tag, v, model_read(p));
    endtask

    task automatic check_outputs(input string tag);
        #1;
        chk({tag, " R6 mem_enable"}, {31'b0, mem_enable}, {31'b0, m_ctl[31]});
        chk({tag, " R9 ecc_irq"}, {31'b0, ecc_irq}, {31'b0, (m_ee != 0)});
        for (int i = 0; i < NB; i++) begin
            chk({tag, " R10 bank_words"}, bank_words[i*32 +: 32], m_bank[i]);
            chk({tag, " R11 bank_active"}, {31'b0, bank_active[i]},
                {31'b0, m_ctl[31] & m_bank[i][0]});
        end
    endtask

    task automatic sweep_reads(input string tag);
        for (int o = 0; o < 256; o++) win_check(tag, 32'(o));
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
        pats[2] = 32'h0000_0000; pats[3] = 32'h5AC3_3CA5;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset values over every low offset, plus outputs
        bus_read(L_IDX, v);
        chk("R3 R1 pointer reset", v, 32'h0);
        check_outputs("R3 reset");
        sweep_reads("R3 R2 reset sweep");

        // R2, R4, R5, R7, R8, R9, R10: write every offset with each pattern
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 256; o++)
                win_write(32'(o), pats[p] ^ {4{8'(o)}});
            check_outputs("pattern");
            sweep_reads("R2 R4 R5 R7 R8 R9 R10 pattern sweep");
        end

        // R2: a large pointer value and the timing offset read all ones
        win_check("R2 far pointer", 32'h0000_0140);
        win_check("R2 timing", 32'h80);

        // R1: pointer readback, other locations ignored and read 0
        bus_write(L_IDX, 32'hDEAD_BEEF); m_ptr = 32'hDEAD_BEEF;
        bus_read(L_IDX, v);
        chk("R1 pointer readback", v, 32'hDEAD_BEEF);
        bus_write(10'h012, 32'h0000_0020);
        bus_write(10'h000, 32'h0000_0020);
        bus_read(L_IDX, v);
        chk("R1 write elsewhere ignored", v, 32'hDEAD_BEEF);
        bus_read(10'h012, v);
        chk("R1 other location reads 0", v, 32'h0);
        @(negedge clk); bus_loc = L_IDX; #2;
        chk("R1 idle rdata 0", bus_rdata, 32'h0);

        // R6, R11: enable edges with bank 0 and absent bank 2 armed
        win_write(32'h20, 32'h0);
        win_write(32'h40, 32'h0000_0001);
        win_write(32'h48, 32'h0000_0001);
        check_outputs("R11 disabled");
        win_write(32'h20, 32'h8000_0000);
        check_outputs("R6 R11 enabled");
        win_check("R6 status after enable", 32'h24);
        win_write(32'h20, 32'h4000_0000);
        check_outputs("R6 disabled");
        win_check("R6 R7 status after disable", 32'h24);
        win_write(32'h24, 32'h0);
        win_check("R7 status write ignored", 32'h24);

        // R9: interrupt rise and fall
        win_write(32'h98, 32'h0000_0FFF);
        check_outputs("R9 masked-out write");
        win_write(32'h98, 32'h0000_1000);
        check_outputs("R9 rise");
        win_write(32'h98, 32'h0);
        check_outputs("R9 fall");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule